// File: doc/BRIEF.md
# Sequential Stream Prefetch Buffers

A small group of FIFO buffers sits next to a data cache and prefetches consecutive cache lines ahead of a miss stream. Each buffer follows one ascending stream of line addresses. It holds the address and the returned data of each prefetched line. When the cache misses, it presents the missing line address. The block compares that address with the oldest entry of every buffer at once.

If a buffer's oldest entry matches and its data has arrived, the block reports a hit in the same cycle and drives the line data for the cache fill. It also removes that entry. If the matching entry is still waiting for memory, the block reports a stall-hit instead, and nothing changes.

If no buffer matches, the block claims a buffer for a new stream. It takes an unused buffer if there is one, and otherwise the least recently used buffer. The claimed buffer is emptied and begins at the line after the miss. The cache fetches the missing line itself.

In the background, buffers with free room request their next line over a valid/ready memory port, one request at a time. A round-robin pointer chooses which buffer requests next.

Top module: `stream_prefetch_buf`

## Requirements
- R1: After reset no buffer is active: `mem_req_valid` is 0, and a lookup reports neither hit nor stall.
- R2: A lookup whose address equals a buffer's oldest entry, with that entry's data already returned, raises `lkp_hit` in the same cycle and drives that line's returned data on `lkp_data`. The entry is then removed, and the following line becomes the oldest entry.
- R3: Only the oldest entry of each buffer is compared. A lookup that matches a younger entry counts as a full miss.
- R4: On a full miss a buffer is claimed and flushed. Its first memory request is for the miss address plus one.
- R5: When every buffer is active, a full miss reclaims the buffer touched least recently. A touch is a hit or a claim.
- R6: While some buffer is inactive, a full miss claims the lowest-numbered inactive buffer.
- R7: A hit makes the hitting buffer the most recently used.
- R8: A lookup that matches an oldest entry whose data is still outstanding raises `lkp_stall`, not `lkp_hit`. It neither removes an entry nor claims a buffer.
- R9: A buffer requests a line only while its occupied plus outstanding entries are fewer than the depth. When all buffers are full, `mem_req_valid` stays 0.
- R10: While `mem_req_ready` is 0, no request is accepted, and the pending request address is held.
- R11: At most one request is outstanding. `mem_req_valid` stays 0 from an accepted request until its response.
- R12: Requesting buffers are served round-robin, starting after the buffer served last. After reset, service starts at buffer 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | Cache miss lookup present this cycle |
| miss_addr | input | AW | Line address of the miss |
| lkp_hit | output | 1 | Oldest entry matched with data present; entry removed |
| lkp_stall | output | 1 | Oldest entry matched, data still outstanding |
| lkp_data | output | DW | Line data for the cache fill on a hit |
| mem_req_valid | output | 1 | Line request to memory |
| mem_req_addr | output | AW | Requested line address |
| mem_req_ready | input | 1 | Memory bus free to accept a request |
| mem_rsp_valid | input | 1 | Response data for the outstanding request |
| mem_rsp_data | input | DW | Returned line data |

## Verification
The bench builds the block with 4 buffers of depth 4 and 32-bit addresses and data. With four buffers, a short series of distinct streams fills the whole set. The fifth stream then forces a reclaim, so the choice of victim and the effect of hits on recency show up as hits or misses on later lookups. A depth of 4 lets a non-oldest entry be probed, and it lets every buffer reach full within a few dozen cycles. A bench memory model with adjustable latency and a bus-free control keeps the data outstanding long enough to observe stall-hits, held requests and the alternating round-robin request order.

// File: rtl/stream_prefetch_buf.sv
module stream_prefetch_buf #(
  parameter int NBUF  = 4,
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          miss_valid,
  input  logic [AW-1:0] miss_addr,
  output logic          lkp_hit,
  output logic          lkp_stall,
  output logic [DW-1:0] lkp_data,
  output logic          mem_req_valid,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_req_ready,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data
);
  localparam int BW = $clog2(NBUF);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0]    ent_addr [NBUF][DEPTH];
  logic [DW-1:0]    ent_data [NBUF][DEPTH];
  logic [DEPTH-1:0] ent_pend [NBUF];
  logic [PW-1:0]    head     [NBUF];
  logic [PW-1:0]    tail     [NBUF];
  logic [CW-1:0]    cnt      [NBUF];
  logic [AW-1:0]    nxt      [NBUF];
  logic [BW-1:0]    age      [NBUF];
  logic [NBUF-1:0]  act;

  logic          rsp_wait, rsp_kill;
  logic [BW-1:0] rsp_buf, rr;
  logic [PW-1:0] rsp_slot;

  logic [NBUF-1:0] hd_match, hd_ready, elig;
  logic [BW-1:0]   sel, victim, tbuf, pick;
  logic            have, do_pop, do_alloc, touch, issue;

  always_comb begin
    hd_match = '0;
    hd_ready = '0;
    for (int b = 0; b < NBUF; b++) begin
      tail[b] = PW'((int'(head[b]) + int'(cnt[b])) % DEPTH);
      if (act[b] && cnt[b] != '0 && ent_addr[b][head[b]] == miss_addr) begin
        hd_match[b] = 1'b1;
        hd_ready[b] = !ent_pend[b][head[b]];
      end
    end
  end

  always_comb begin
    sel = '0;
    for (int b = NBUF - 1; b >= 0; b--)
      if (hd_ready[b]) sel = BW'(b);
  end

  assign lkp_hit   = miss_valid & (|hd_ready);
  assign lkp_stall = miss_valid & (|hd_match) & ~(|hd_ready);
  assign lkp_data  = ent_data[sel][head[sel]];
  assign do_pop    = lkp_hit;
  assign do_alloc  = miss_valid & ~(|hd_match);

  always_comb begin
    victim = '0;
    for (int b = NBUF - 1; b >= 0; b--)
      if (age[b] == BW'(NBUF - 1)) victim = BW'(b);
    for (int b = NBUF - 1; b >= 0; b--)
      if (!act[b]) victim = BW'(b);
  end

  assign tbuf  = do_pop ? sel : victim;
  assign touch = do_pop | do_alloc;

  always_comb begin
    for (int b = 0; b < NBUF; b++)
      elig[b] = act[b] && (cnt[b] < CW'(DEPTH)) && !(do_alloc && victim == BW'(b));
    pick = '0;
    have = 1'b0;
    for (int k = NBUF - 1; k >= 0; k--) begin
      if (elig[(int'(rr) + k) % NBUF]) begin
        pick = BW'((int'(rr) + k) % NBUF);
        have = 1'b1;
      end
    end
  end

  assign mem_req_valid = !rsp_wait && have;
  assign mem_req_addr  = nxt[pick];
  assign issue         = mem_req_valid && mem_req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act      <= '0;
      rsp_wait <= 1'b0;
      rsp_kill <= 1'b0;
      rsp_buf  <= '0;
      rsp_slot <= '0;
      rr       <= '0;
      for (int b = 0; b < NBUF; b++) begin
        head[b]     <= '0;
        cnt[b]      <= '0;
        nxt[b]      <= '0;
        age[b]      <= BW'(b);
        ent_pend[b] <= '0;
        for (int d = 0; d < DEPTH; d++) begin
          ent_addr[b][d] <= '0;
          ent_data[b][d] <= '0;
        end
      end
    end else begin
      for (int b = 0; b < NBUF; b++) begin
        if (do_alloc && victim == BW'(b)) begin
          act[b]      <= 1'b1;
          head[b]     <= '0;
          cnt[b]      <= '0;
          nxt[b]      <= miss_addr + AW'(1);
          ent_pend[b] <= '0;
        end else begin
          if (do_pop && sel == BW'(b))
            head[b] <= PW'((int'(head[b]) + 1) % DEPTH);
          cnt[b] <= cnt[b] + CW'(issue && pick == BW'(b)) - CW'(do_pop && sel == BW'(b));
          if (issue && pick == BW'(b)) begin
            ent_addr[b][tail[b]] <= nxt[b];
            ent_pend[b][tail[b]] <= 1'b1;
            nxt[b]               <= nxt[b] + AW'(1);
          end
          if (mem_rsp_valid && rsp_wait && !rsp_kill && rsp_buf == BW'(b)) begin
            ent_data[b][rsp_slot] <= mem_rsp_data;
            ent_pend[b][rsp_slot] <= 1'b0;
          end
        end
        if (touch) begin
          if (tbuf == BW'(b))      age[b] <= '0;
          else if (age[b] < age[tbuf]) age[b] <= age[b] + BW'(1);
        end
      end
      if (issue) begin
        rsp_wait <= 1'b1;
        rsp_kill <= 1'b0;
        rsp_buf  <= pick;
        rsp_slot <= tail[pick];
        rr       <= BW'((int'(pick) + 1) % NBUF);
      end else if (rsp_wait) begin
        if (mem_rsp_valid) rsp_wait <= 1'b0;
        if (do_alloc && victim == rsp_buf) rsp_kill <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sbuf_chk.sv
module sbuf_chk (
  input logic clk,
  input logic rst_n,
  input logic miss_valid,
  input logic lkp_hit,
  input logic lkp_stall,
  input logic mem_req_valid,
  input logic mem_req_ready,
  input logic mem_rsp_valid,
  input logic rsp_wait
);
  AST_HIT_STALL_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(lkp_hit && lkp_stall)); // R8
  AST_RESULT_NEEDS_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n) (lkp_hit || lkp_stall) |-> miss_valid); // R2
  AST_QUIET_WHILE_WAIT: assert property (@(posedge clk) disable iff (!rst_n) rsp_wait |-> !mem_req_valid); // R11
  AST_ACCEPT_SETS_WAIT: assert property (@(posedge clk) disable iff (!rst_n) (mem_req_valid && mem_req_ready) |=> rsp_wait); // R11
  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n) (!rsp_wait && !mem_req_ready) |=> !rsp_wait); // R10
  AST_RSP_ENDS_WAIT: assert property (@(posedge clk) disable iff (!rst_n) (rsp_wait && mem_rsp_valid) |=> !rsp_wait); // R11
endmodule

bind stream_prefetch_buf sbuf_chk u_chk (
  .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .lkp_hit(lkp_hit),
  .lkp_stall(lkp_stall), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_rsp_valid(mem_rsp_valid), .rsp_wait(rsp_wait)
);

// File: tb/tb_stream_prefetch_buf.sv
`timescale 1ns/1ps
module tb_stream_prefetch_buf;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        miss_valid = 1'b0;
  logic [31:0] miss_addr = '0;
  logic        lkp_hit, lkp_stall;
  logic [31:0] lkp_data;
  logic        mem_req_valid;
  logic [31:0] mem_req_addr;
  logic        mem_req_ready = 1'b1;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  int checks = 0, errors = 0;
  int lat = 1, cd = 0, log_n = 0;
  logic [31:0] pa = '0;
  logic [31:0] req_log [64];
  bit done = 0;

  always #2.5 clk = ~clk;

  stream_prefetch_buf dut (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_addr(miss_addr),
    .lkp_hit(lkp_hit), .lkp_stall(lkp_stall), .lkp_data(lkp_data),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr), .mem_req_ready(mem_req_ready),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  function automatic logic [31:0] line_data(input logic [31:0] a);
    return {a[15:0], a[31:16]} ^ 32'hC3A5_0F1E;
  endfunction

  // memory model: one response, lat cycles after acceptance
  initial begin
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (cd > 0) begin
        cd--;
        if (cd == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = line_data(pa);
        end
      end
      #1;
      if (rst_n && mem_req_valid && mem_req_ready) begin
        pa = mem_req_addr;
        cd = lat;
        if (log_n < 64) req_log[log_n] = pa;
        log_n++;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic lookup(input logic [31:0] a, input logic eh, input logic es, input string req);
    @(negedge clk);
    miss_valid = 1'b1;
    miss_addr  = a;
    #1;
    check(req, {31'd0, lkp_hit}, {31'd0, eh});
    check(req, {31'd0, lkp_stall}, {31'd0, es});
    if (eh) check(req, lkp_data, line_data(a));
    @(negedge clk);
    miss_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cd = 0;
    log_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // {line address, expected hit, expected stall}
  localparam int NV = 13;
  localparam logic [33:0] VEC [NV] = '{
    {32'h100, 2'b00}, {32'h101, 2'b10}, {32'h103, 2'b00}, {32'h102, 2'b10},
    {32'h500, 2'b00}, {32'h200, 2'b00}, {32'h300, 2'b00}, {32'h103, 2'b10},
    {32'h501, 2'b10}, {32'h201, 2'b10}, {32'h301, 2'b10}, {32'h104, 2'b10},
    {32'h105, 2'b10}
  };
  localparam string VTAG [NV] = '{
    "R4", "R2", "R3", "R2", "R6", "R6", "R5", "R7", "R5", "R5", "R5", "R2", "R2"
  };

  initial begin
    int seen;
    repeat (3) @(negedge clk);
    #1;
    check("R1 req after reset", {31'd0, mem_req_valid}, 32'd0);
    check("R1 hit after reset", {31'd0, lkp_hit}, 32'd0);
    check("R1 stall after reset", {31'd0, lkp_stall}, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      lookup(VEC[i][33:2], VEC[i][1], VEC[i][0], VTAG[i]);
      repeat (40) @(negedge clk);
    end

    #1;
    check("R9 all buffers full", {31'd0, mem_req_valid}, 32'd0);

    // stall on an outstanding head
    lat = 12;
    lookup(32'h700, 1'b0, 1'b0, "R4 new stream");
    lookup(32'h701, 1'b0, 1'b1, "R8 pending head");
    #1;
    check("R11 no second request", {31'd0, mem_req_valid}, 32'd0);
    lat = 1;
    repeat (40) @(negedge clk);
    lookup(32'h701, 1'b1, 1'b0, "R8 entry kept after stall");

    // bus busy
    repeat (40) @(negedge clk);
    mem_req_ready = 1'b0;
    lookup(32'h800, 1'b0, 1'b0, "R4 stream while busy");
    @(negedge clk);
    #1;
    check("R10 request pending", {31'd0, mem_req_valid}, 32'd1);
    check("R10 request address", mem_req_addr, 32'h801);
    seen = log_n;
    repeat (20) @(negedge clk);
    #1;
    check("R10 nothing accepted", seen, log_n);
    check("R10 address held", mem_req_addr, 32'h801);
    mem_req_ready = 1'b1;
    repeat (40) @(negedge clk);
    lookup(32'h801, 1'b1, 1'b0, "R10 filled after release");
    lookup(32'h802, 1'b1, 1'b0, "R2 next line");

    // round-robin order
    do_reset();
    mem_req_ready = 1'b0;
    lookup(32'h900, 1'b0, 1'b0, "R6 first stream");
    lookup(32'hA00, 1'b0, 1'b0, "R6 second stream");
    mem_req_ready = 1'b1;
    repeat (20) @(negedge clk);
    check("R12 order 0", req_log[0], 32'h901);
    check("R12 order 1", req_log[1], 32'hA01);
    check("R12 order 2", req_log[2], 32'h902);
    check("R12 order 3", req_log[3], 32'hA02);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule